// File: doc/BRIEF.md
# Endpoint Receive Packet Read Port

This block lets a processor drain one received packet at a time from a small set of endpoint buffers, one 32-bit word per read. A simple buffer model sits inside: packet words are written into a per-endpoint store, and a commit strobe then records the packet's byte length and whether it arrived with an error. The processor picks an endpoint through a plain select input. It then reads a status word and pulls the data words until the byte count runs out.

The status word has three fields. Bits 9:0 hold the number of bytes still unread. Bit 10 is a data-valid flag. Bit 11 is a packet-ready flag. Every data read returns the next word of the packet, with the earliest byte in the least significant lane, and lowers the count. When the count reaches zero, a sticky end-of-packet interrupt flag rises.

Endpoints are either isochronous or not, as set by a parameter mask. A packet that arrives with an error on an isochronous endpoint is still delivered, with the valid flag clear. On other endpoints an erroneous packet is discarded. A bus reset marks every pending packet as invalid.

Top module: `ep_rx_drain`

## Requirements
- R1: After reset the status word, the read data and the end-of-packet flag are all 0.
- R2: One cycle after a select of an endpoint holding a good packet, the status word shows bit 11 = 1, bit 10 = 1, and the packet length in bits 9:0.
- R3: A select of an endpoint with no pending packet gives a status word of 0.
- R4: Each read while ready returns the next stored word, with byte 0 of the packet in bits 7:0. When more than 4 bytes remain, the count in bits 9:0 drops by 4.
- R5: When 4 or fewer bytes remain, a read returns only those bytes, with the upper unused byte lanes reading 0, and the count becomes 0.
- R6: The read that brings the count to zero clears the ready flag, which leaves the status word at 0. The same read sets the end-of-packet flag, which stays set until cleared.
- R7: A read while bit 11 is 0 returns 0 and leaves the status word and the end-of-packet flag unchanged.
- R8: An erroneous packet on an isochronous endpoint is still delivered in full, with bit 10 = 0 and bit 11 = 1.
- R9: An erroneous packet on a non-isochronous endpoint is discarded: a later select of that endpoint gives status 0, and the end-of-packet flag does not rise.
- R10: A bus reset pulse marks every pending packet invalid, so its later select shows bit 10 = 0.
- R11: A zero-length packet shows bit 11 = 1 with a count of 0. One read of it returns 0 and completes the packet as in R6.
- R12: Status bits 31:12 always read 0.
- R13: An interrupt-clear pulse clears the end-of-packet flag. If a final read happens in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one word into the buffer model |
| wr_ep | input | EP_W | Endpoint written |
| wr_addr | input | AW | Word index in that endpoint's buffer |
| wr_data | input | 32 | Word written, first byte in bits 7:0 |
| cmt_en | input | 1 | Commit a received packet |
| cmt_ep | input | EP_W | Endpoint committed |
| cmt_len | input | LEN_W | Packet byte length |
| cmt_err | input | 1 | Packet arrived with an error |
| bus_rst | input | 1 | Bus reset seen; pending packets become invalid |
| sel_en | input | 1 | Select the endpoint on ep_sel |
| ep_sel | input | EP_W | Endpoint to read |
| rd_en | input | 1 | Read one data word |
| irq_clr | input | 1 | Clear the end-of-packet flag |
| rd_data | output | 32 | Word returned by the last read |
| rx_status | output | 32 | Ready, valid and remaining count |
| eop_irq | output | 1 | Sticky end-of-packet interrupt flag |

## Verification
Every result is due one clock edge after its stimulus. Select, read, bus reset, commit and interrupt clear each go through a single register stage, so rd_data, rx_status and eop_irq change at the edge that samples the request. The bench drives each input just after a rising edge and samples one nanosecond after the next rising edge. Expected words, counts and flags come from an independent model of each endpoint's buffer that the bench updates step by step.

// File: rtl/ep_rx_drain.sv
module ep_rx_drain #(
  parameter int NUM_EP = 4,
  parameter int BUF_WORDS = 16,
  parameter int LEN_W = 10,
  parameter logic [NUM_EP-1:0] ISO_MASK = 4'b1010,
  localparam int EP_W = $clog2(NUM_EP),
  localparam int AW = $clog2(BUF_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [EP_W-1:0]  wr_ep,
  input  logic [AW-1:0]    wr_addr,
  input  logic [31:0]      wr_data,
  input  logic             cmt_en,
  input  logic [EP_W-1:0]  cmt_ep,
  input  logic [LEN_W-1:0] cmt_len,
  input  logic             cmt_err,
  input  logic             bus_rst,
  input  logic             sel_en,
  input  logic [EP_W-1:0]  ep_sel,
  input  logic             rd_en,
  input  logic             irq_clr,
  output logic [31:0]      rd_data,
  output logic [31:0]      rx_status,
  output logic             eop_irq
);
  localparam int DEPTH = NUM_EP * BUF_WORDS;

  logic [31:0]      mem [DEPTH];
  logic [NUM_EP-1:0] full, bad;
  logic [LEN_W-1:0] len_tab [NUM_EP];
  logic [EP_W-1:0]  cur;
  logic [AW-1:0]    ptr;
  logic [LEN_W-1:0] rem, take;
  logic             rdy, dv;
  logic [31:0]      rd_q, rd_word;
  logic             do_rd, last;

  assign take    = (rem > LEN_W'(4)) ? LEN_W'(4) : rem;
  assign do_rd   = rd_en && !sel_en && rdy;
  assign last    = do_rd && (rem <= LEN_W'(4));
  assign rd_data = rd_q;
  assign rx_status = {20'b0, rdy, dv, rem};

  always_comb begin
    rd_word = mem[{cur, ptr}];
    for (int b = 0; b < 4; b++)
      if (LEN_W'(b) >= take) rd_word[8*b +: 8] = 8'h00;
  end

  always_ff @(posedge clk)
    if (wr_en) mem[{wr_ep, wr_addr}] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= '0;
      bad  <= '0;
      for (int e = 0; e < NUM_EP; e++) len_tab[e] <= '0;
      cur  <= '0;
      ptr  <= '0;
      rem  <= '0;
      rdy  <= 1'b0;
      dv   <= 1'b0;
      rd_q <= '0;
      eop_irq <= 1'b0;
    end else begin
      if (irq_clr) eop_irq <= 1'b0;
      if (sel_en) begin
        cur <= ep_sel;
        ptr <= '0;
        if (full[ep_sel]) begin
          rdy <= 1'b1;
          dv  <= !bad[ep_sel];
          rem <= len_tab[ep_sel];
        end else begin
          rdy <= 1'b0;
          dv  <= 1'b0;
          rem <= '0;
        end
      end else if (rd_en) begin
        if (!rdy) begin
          rd_q <= '0;
        end else begin
          rd_q <= rd_word;
          rem  <= rem - take;
          ptr  <= ptr + 1'b1;
          if (last) begin
            rdy <= 1'b0;
            dv  <= 1'b0;
            full[cur] <= 1'b0;
            eop_irq <= 1'b1;
          end
        end
      end
      if (cmt_en && (!cmt_err || ISO_MASK[cmt_ep])) begin
        full[cmt_ep]    <= 1'b1;
        bad[cmt_ep]     <= cmt_err;
        len_tab[cmt_ep] <= cmt_len;
      end
      if (bus_rst) begin
        bad <= bad | full;
        if (rdy && !last) dv <= 1'b0;
      end
    end
  end

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    do_rd && rem > LEN_W'(4) |=> rdy && rem == $past(rem) - LEN_W'(4)); // R4
  AST_LAST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !rdy && rem == '0 && eop_irq); // R6
  AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !sel_en && !rdy && !irq_clr |=> rd_data == '0 && $stable(rem) && $stable(eop_irq)); // R7
  AST_SEL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    sel_en && !full[ep_sel] |=> !rdy && rem == '0); // R3
  AST_ERR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_en && cmt_err && !ISO_MASK[cmt_ep] && !full[cmt_ep] |=> !full[$past(cmt_ep)]); // R9
  AST_CLR_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr && !last |=> !eop_irq); // R13
endmodule

// File: tb/sim_ep_rx_drain.sv
`timescale 1ns/1ps
module sim_ep_rx_drain;
  localparam logic [3:0] ISO = 4'b1010;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, cmt_en = 0, cmt_err = 0, bus_rst = 0, sel_en = 0, rd_en = 0, irq_clr = 0;
  logic [1:0] wr_ep = 0, cmt_ep = 0, ep_sel = 0;
  logic [3:0] wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic [9:0] cmt_len = 0;
  logic [31:0] rd_data, rx_status;
  logic eop_irq;
  int checks = 0, fails = 0;
  logic [31:0] bw [4][16];
  bit mfull [4], mbad [4];
  int mlen [4];

  ep_rx_drain u0 (.clk, .rst_n, .wr_en, .wr_ep, .wr_addr, .wr_data, .cmt_en, .cmt_ep,
    .cmt_len, .cmt_err, .bus_rst, .sel_en, .ep_sel, .rd_en, .irq_clr,
    .rd_data, .rx_status, .eop_irq);

  always #10 clk = ~clk;

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  function automatic logic [31:0] st(bit r, bit d, int l);
    return (32'(r) << 11) | (32'(d) << 10) | 32'(l);
  endfunction

  function automatic logic [31:0] masked(logic [31:0] w, int rem);
    logic [31:0] m = w;
    for (int b = 0; b < 4; b++) if (b >= rem) m[8*b +: 8] = 8'h00;
    return m;
  endfunction

  task automatic load(int ep, int len, bit err);
    for (int i = 0; i < (len + 3) / 4; i++) begin
      bw[ep][i] = $urandom;
      wr_en = 1; wr_ep = 2'(ep); wr_addr = 4'(i); wr_data = bw[ep][i];
      tick();
    end
    wr_en = 0;
    cmt_en = 1; cmt_ep = 2'(ep); cmt_len = 10'(len); cmt_err = err;
    tick();
    cmt_en = 0; cmt_err = 0;
    if (!err || ISO[ep]) begin mfull[ep] = 1; mlen[ep] = len; mbad[ep] = err; end
  endtask

  task automatic select(int ep, string tag);
    logic [31:0] e;
    sel_en = 1; ep_sel = 2'(ep);
    tick();
    sel_en = 0;
    e = mfull[ep] ? st(1, !mbad[ep], mlen[ep]) : 32'h0;
    chk(rx_status == e, tag, rx_status, e);
    chk(rx_status[31:12] == 0, "R12 reserved bits", rx_status, 32'h0);
  endtask

  task automatic drain(int ep, string tag);
    int rem = mlen[ep];
    int i = 0;
    logic [31:0] e;
    do begin
      rd_en = 1;
      tick();
      rd_en = 0;
      e = masked(bw[ep][i], rem);
      rem = (rem > 4) ? rem - 4 : 0;
      chk(rd_data == e, rem > 0 ? "R4 data word" : "R5 final word", rd_data, e);
      e = (rem > 0) ? st(1, !mbad[ep], rem) : 32'h0;
      chk(rx_status == e, rem > 0 ? "R4 count" : "R6 status after last", rx_status, e);
      if (rem > 0) chk(!eop_irq, "R6 no early flag", 32'(eop_irq), 0);
      i++;
    end while (rem > 0);
    chk(eop_irq, tag, 32'(eop_irq), 1);
    mfull[ep] = 0;
    irq_clr = 1; tick(); irq_clr = 0;
    chk(!eop_irq, "R13 clear", 32'(eop_irq), 0);
  endtask

  initial begin
    void'($urandom(1234));
    repeat (3) tick();
    chk(rx_status == 0, "R1 status", rx_status, 0);
    chk(rd_data == 0, "R1 data", rd_data, 0);
    chk(!eop_irq, "R1 flag", 32'(eop_irq), 0);
    rst_n = 1; tick();

    rd_en = 1; tick(); rd_en = 0;
    chk(rd_data == 0 && rx_status == 0 && !eop_irq, "R7 idle read", rd_data, 0);
    select(2, "R3 empty select");

    load(1, 10, 1);
    select(1, "R8 iso error delivered");
    drain(1, "R8 iso error flag");

    load(0, 8, 1);
    select(0, "R9 dropped packet");
    chk(!eop_irq, "R9 no flag", 32'(eop_irq), 0);

    load(2, 12, 0);
    bus_rst = 1; tick(); bus_rst = 0;
    for (int e = 0; e < 4; e++) if (mfull[e]) mbad[e] = 1;
    select(2, "R10 invalid after bus reset");
    drain(2, "R10 flag");

    load(3, 0, 0);
    select(3, "R11 zero length");
    rd_en = 1; tick(); rd_en = 0;
    chk(rd_data == 0 && rx_status == 0, "R11 zero read", rx_status, 0);
    chk(eop_irq, "R11 flag", 32'(eop_irq), 1);
    mfull[3] = 0;
    rd_en = 1; tick(); rd_en = 0;
    chk(rd_data == 0 && eop_irq, "R7 read after end", rd_data, 0);

    load(0, 3, 0);
    select(0, "R2 short packet");
    rd_en = 1; irq_clr = 1; tick(); rd_en = 0; irq_clr = 0;
    chk(rd_data == masked(bw[0][0], 3), "R5 partial", rd_data, masked(bw[0][0], 3));
    chk(eop_irq, "R13 set wins", 32'(eop_irq), 1);
    mfull[0] = 0;
    irq_clr = 1; tick(); irq_clr = 0;
    chk(!eop_irq, "R13 clear", 32'(eop_irq), 0);

    for (int n = 0; n < 60; n++) begin
      int ep = $urandom % 4;
      int len = $urandom % 65;
      bit err = ($urandom % 4) == 0;
      if (($urandom % 8) != 0) load(ep, len, err);
      select(ep, mfull[ep] ? (mbad[ep] ? "R8 random" : "R2 random") : "R3/R9 random");
      if (mfull[ep]) drain(ep, "R6 random flag");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule